// File: doc/BRIEF.md
# Add/Subtract Flag Generator

This block is the arithmetic half of an integer execute stage. In a single combinational path it evaluates six 32-bit operations: plain add, add with incoming carry, subtract, reverse subtract, subtract with carry and reverse subtract with carry. It returns the result together with new negative, zero, carry and overflow flags. The current carry flag is taken from the current status word. The flags that the operation does not set come back unchanged from that same word.

Every operation goes through one adder that is one bit wider than the data. For the subtract forms the second addend is inverted, and the carry-in is either 1 or the current carry flag. The adder's carry-out is therefore already the "no borrow" value that the carry flag holds after a subtraction. The reverse forms swap the two operands in front of the adder.

When the set-flags bit is on and the destination register index selects the program counter, no flags are computed from the result. The block instead raises a restore strobe, and its flag output presents the saved status word's flags. The surrounding pipeline uses the strobe to copy the saved word into the current one.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (add) gives result = A + B modulo 2^32. Opcode 1 (add with carry) gives A + B + C, where C is bit 29 of the current status word.
- R2: Opcode 2 (subtract) gives A - B. Opcode 3 (reverse subtract) gives B - A. Both are modulo 2^32.
- R3: Opcode 4 gives A - B - (1 - C). Opcode 5 gives B - A - (1 - C). Both are modulo 2^32.
- R4: With set-flags on and no restore, flag output bit 3 (N) equals result bit 31, and bit 2 (Z) is 1 exactly when the result is zero.
- R5: With set-flags on and no restore, flag bit 1 (C) is the unsigned carry out of the add forms. For the subtract forms it is 1 exactly when no borrow occurs, counting the borrow-in.
- R6: With set-flags on and no restore, flag bit 0 (V) is 1 exactly when the signed value of the whole operation, carry term included, falls outside [-2^31, 2^31-1].
- R7: With set-flags on and destination index 15, the restore output is 1. The flag output is then the saved status word's bits 31:28, in the order N, Z, C, V.
- R8: With set-flags off, the restore output is 0 and the flag output equals bits 31:28 of the current status word, whatever the opcode or destination.
- R9: Opcodes 6 and 7 behave exactly as opcode 0 (add), for both the result and the flags.
- R10: The result is the arithmetic value in every case, including a restore. The restore output is never 1 unless set-flags is on and the destination index is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| opcode_i | input | 3 | Operation select (0 add, 1 adc, 2 sub, 3 rsb, 4 sbc, 5 rsc) |
| set_flags_i | input | 1 | Set-flags bit of the instruction |
| dst_idx_i | input | 4 | Destination register index |
| cur_status_i | input | 32 | Current status word (flags N,Z,C,V in bits 31:28) |
| saved_status_i | input | 32 | Saved status word |
| result_o | output | 32 | Arithmetic result |
| flags_o | output | 4 | New flags {N,Z,C,V} |
| restore_o | output | 1 | Request to copy the saved status word into the current one |

## Verification
The block holds no state, so an internal fault shows at the ports as soon as the inputs settle. A wrong operand swap or a wrong carry-in gives a result that is off by one or mirrored. That error is visible in the same evaluation, most easily on subtract with carry and reverse subtract with carry when C is 0. A mis-inverted carry-out or a wrong overflow rule appears as a wrong flag on operands that sit at the unsigned or signed boundary, so random vectors are mixed with directed operands such as 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. A faulty restore decode shows up as a missing or false strobe when the destination index is 15, or as a flag output taken from the wrong status word.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_ADC  = 3'd1,
    OPC_SUB  = 3'd2,
    OPC_RSB  = 3'd3,
    OPC_SBC  = 3'd4,
    OPC_RSC  = 3'd5,
    OPC_RES6 = 3'd6,
    OPC_RES7 = 3'd7
  } arith_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flag_t;

  // Operation inverts its second addend (any subtract form)
  function automatic logic op_is_sub(arith_op_e op);
    return (op == OPC_SUB) || (op == OPC_RSB) || (op == OPC_SBC) || (op == OPC_RSC);
  endfunction

  // Operation exchanges the operands before the adder
  function automatic logic op_swaps(arith_op_e op);
    return (op == OPC_RSB) || (op == OPC_RSC);
  endfunction

  // Carry-in comes from the current C flag
  function automatic logic op_takes_carry(arith_op_e op);
    return (op == OPC_ADC) || (op == OPC_SBC) || (op == OPC_RSC);
  endfunction

endpackage

// File: rtl/operand_steer.sv
module operand_steer
  import arith_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [2:0]       opcode_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] addend_x_o,
  output logic [WIDTH-1:0] addend_y_o,
  output logic             cin_o,
  output logic             sub_mode_o
);

  arith_op_e op;
  logic      swap;
  logic      sub;
  logic      use_c;
  logic [WIDTH-1:0] first;
  logic [WIDTH-1:0] second;

  assign op    = arith_op_e'(opcode_i);
  assign swap  = op_swaps(op);
  assign sub   = op_is_sub(op);
  assign use_c = op_takes_carry(op);

  always_comb begin
    if (swap) begin
      first  = op_b_i;
      second = op_a_i;
    end else begin
      first  = op_a_i;
      second = op_b_i;
    end
  end

  assign addend_x_o = first;
  assign addend_y_o = sub ? ~second : second;

  // Carry-in: with-carry forms use C; plain subtract forms use 1; plain add uses 0
  always_comb begin
    if (use_c)    cin_o = carry_i;
    else if (sub) cin_o = 1'b1;
    else          cin_o = 1'b0;
  end

  assign sub_mode_o = sub;

endmodule

// File: rtl/wide_adder.sv
module wide_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int EXT_W = WIDTH + 1;
  localparam int MSB   = WIDTH - 1;

  function automatic logic [EXT_W-1:0] add_ext(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic             c);
    return {1'b0, x} + {1'b0, y} + {{(EXT_W-1){1'b0}}, c};
  endfunction

  function automatic logic sign_overflow(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  logic [EXT_W-1:0] ext_sum;

  assign ext_sum = add_ext(x_i, y_i, cin_i);
  assign sum_o   = ext_sum[WIDTH-1:0];
  assign cout_o  = ext_sum[EXT_W-1];
  assign ovf_o   = sign_overflow(x_i[MSB], y_i[MSB], ext_sum[MSB]);

endmodule

// File: rtl/flag_select.sv
module flag_select
  import arith_flag_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IDX_W     = 4,
  parameter int PC_INDEX  = 15
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic             set_flags_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  flag_t            cur_flags_i,
  input  flag_t            saved_flags_i,
  output flag_t            flags_o,
  output logic             restore_o
);

  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_INDEX);

  logic  to_pc;
  flag_t computed;

  assign to_pc = (dst_idx_i == PC_SEL);

  always_comb begin
    computed.n = sum_i[WIDTH-1];
    computed.z = (sum_i == '0);
    computed.c = cout_i;
    computed.v = ovf_i;
  end

  always_comb begin
    restore_o = 1'b0;
    flags_o   = cur_flags_i;
    if (set_flags_i) begin
      if (to_pc) begin
        restore_o = 1'b1;
        flags_o   = saved_flags_i;
      end else begin
        flags_o   = computed;
      end
    end
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_flag_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int IDX_W    = 4,
  parameter int PC_INDEX = 15,
  parameter int STAT_W   = 32,
  parameter int N_POS    = 31,
  parameter int Z_POS    = 30,
  parameter int C_POS    = 29,
  parameter int V_POS    = 28
) (
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic [2:0]        opcode_i,
  input  logic              set_flags_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [STAT_W-1:0] cur_status_i,
  input  logic [STAT_W-1:0] saved_status_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [3:0]        flags_o,
  output logic              restore_o
);

  // Named internal events, visible to the bound checker
  logic [WIDTH-1:0] addend_x_w;
  logic [WIDTH-1:0] addend_y_w;
  logic             cin_w;
  logic             sub_mode_w;
  logic             carry_out_w;
  logic             ovf_w;
  flag_t            cur_flags_w;
  flag_t            saved_flags_w;
  flag_t            new_flags_w;

  logic unused_status_bits;
  assign unused_status_bits = ^{cur_status_i, saved_status_i, sub_mode_w};

  function automatic flag_t pick_flags(input logic [STAT_W-1:0] word);
    flag_t f;
    f.n = word[N_POS];
    f.z = word[Z_POS];
    f.c = word[C_POS];
    f.v = word[V_POS];
    return f;
  endfunction

  assign cur_flags_w   = pick_flags(cur_status_i);
  assign saved_flags_w = pick_flags(saved_status_i);

  operand_steer #(.WIDTH(WIDTH)) u_steer (
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .opcode_i   (opcode_i),
    .carry_i    (cur_flags_w.c),
    .addend_x_o (addend_x_w),
    .addend_y_o (addend_y_w),
    .cin_o      (cin_w),
    .sub_mode_o (sub_mode_w)
  );

  wide_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i    (addend_x_w),
    .y_i    (addend_y_w),
    .cin_i  (cin_w),
    .sum_o  (result_o),
    .cout_o (carry_out_w),
    .ovf_o  (ovf_w)
  );

  flag_select #(.WIDTH(WIDTH), .IDX_W(IDX_W), .PC_INDEX(PC_INDEX)) u_flags (
    .sum_i         (result_o),
    .cout_i        (carry_out_w),
    .ovf_i         (ovf_w),
    .set_flags_i   (set_flags_i),
    .dst_idx_i     (dst_idx_i),
    .cur_flags_i   (cur_flags_w),
    .saved_flags_i (saved_flags_w),
    .flags_o       (new_flags_w),
    .restore_o     (restore_o)
  );

  assign flags_o = new_flags_w;

endmodule

// File: rtl/arith_flag_chk.sv
module arith_flag_chk #(
  parameter int WIDTH    = 32,
  parameter int IDX_W    = 4,
  parameter int PC_INDEX = 15,
  parameter int STAT_W   = 32
) (
  input logic [WIDTH-1:0]  op_a_i,
  input logic [WIDTH-1:0]  op_b_i,
  input logic [2:0]        opcode_i,
  input logic              set_flags_i,
  input logic [IDX_W-1:0]  dst_idx_i,
  input logic [STAT_W-1:0] cur_status_i,
  input logic [STAT_W-1:0] saved_status_i,
  input logic [WIDTH-1:0]  result_o,
  input logic [3:0]        flags_o,
  input logic              restore_o,
  input logic              sub_mode_w,
  input logic              carry_out_w
);

  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_INDEX);

  logic pc_dst;
  logic computing;
  logic is_sub_op;

  assign pc_dst    = (dst_idx_i == PC_SEL);
  assign computing = set_flags_i && !pc_dst;
  assign is_sub_op = (opcode_i >= 3'd2) && (opcode_i <= 3'd5);

  always_comb begin
    if (!$isunknown({op_a_i, op_b_i, opcode_i, set_flags_i, dst_idx_i,
                     cur_status_i, saved_status_i})) begin
      // R10
      restore_gate_chk: assert (!restore_o || (set_flags_i && pc_dst));
      // R7
      restore_flags_chk: assert (!(set_flags_i && pc_dst) ||
                                 (restore_o && flags_o == saved_status_i[STAT_W-1 -: 4]));
      // R8
      pass_flags_chk: assert (set_flags_i || (!restore_o && flags_o == cur_status_i[STAT_W-1 -: 4]));
      // R4
      nz_flags_chk: assert (!computing ||
                            (flags_o[3] == result_o[WIDTH-1] && flags_o[2] == (result_o == '0)));
      // R5
      carry_path_chk: assert (!computing || flags_o[1] == carry_out_w);
      // R2
      sub_mode_chk: assert (sub_mode_w == is_sub_op);
      // R6
      no_overflow_chk: assert (!computing || opcode_i != 3'd0 || op_a_i[WIDTH-1] != op_b_i[WIDTH-1] ||
                               flags_o[0] == (result_o[WIDTH-1] != op_a_i[WIDTH-1]));
      // R1
      add_result_chk: assert (opcode_i != 3'd0 || result_o == op_a_i + op_b_i);
    end
  end

endmodule

bind arith_flag_unit arith_flag_chk #(
  .WIDTH(WIDTH), .IDX_W(IDX_W), .PC_INDEX(PC_INDEX), .STAT_W(STAT_W)
) u_arith_flag_chk (
  .op_a_i         (op_a_i),
  .op_b_i         (op_b_i),
  .opcode_i       (opcode_i),
  .set_flags_i    (set_flags_i),
  .dst_idx_i      (dst_idx_i),
  .cur_status_i   (cur_status_i),
  .saved_status_i (saved_status_i),
  .result_o       (result_o),
  .flags_o        (flags_o),
  .restore_o      (restore_o),
  .sub_mode_w     (sub_mode_w),
  .carry_out_w    (carry_out_w)
);

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b, cur_s, sav_s;
  logic [2:0]  opc;
  logic        sf;
  logic [3:0]  dst;
  logic [31:0] res;
  logic [3:0]  flg;
  logic        rst_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;   // 50 MHz

  arith_flag_unit i_arith_flag_unit (
    .op_a_i(a), .op_b_i(b), .opcode_i(opc), .set_flags_i(sf), .dst_idx_i(dst),
    .cur_status_i(cur_s), .saved_status_i(sav_s),
    .result_o(res), .flags_o(flg), .restore_o(rst_q)
  );

  // Expected model: signed/unsigned 64-bit arithmetic
  function automatic longint unsigned ev_first(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    return (op == 3'd3 || op == 3'd5) ? {32'd0, y} : {32'd0, x};
  endfunction
  function automatic longint unsigned ev_second(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    return (op == 3'd3 || op == 3'd5) ? {32'd0, x} : {32'd0, y};
  endfunction
  function automatic bit ev_is_sub(input logic [2:0] op);
    return op >= 3'd2 && op <= 3'd5;
  endfunction
  function automatic longint unsigned ev_extra(input logic [2:0] op, input bit c);
    // add-side carry term for ADC; borrow term for SBC/RSC
    if (op == 3'd1) return c ? 64'd1 : 64'd0;
    if (op == 3'd4 || op == 3'd5) return c ? 64'd0 : 64'd1;
    return 64'd0;
  endfunction

  function automatic logic [31:0] ev_result(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y, input bit c);
    longint unsigned p = ev_first(op, x, y);
    longint unsigned q = ev_second(op, x, y);
    longint unsigned t = ev_extra(op, c);
    longint unsigned r;
    if (ev_is_sub(op)) r = p - q - t;
    else               r = p + q + t;
    return r[31:0];
  endfunction

  function automatic bit ev_carry(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y, input bit c);
    longint unsigned p = ev_first(op, x, y);
    longint unsigned q = ev_second(op, x, y);
    longint unsigned t = ev_extra(op, c);
    if (ev_is_sub(op)) return p >= q + t;
    return (p + q + t) > 64'hFFFF_FFFF;
  endfunction

  function automatic bit ev_ovf(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y, input bit c);
    logic [31:0] fp = ev_first(op, x, y) & 64'hFFFF_FFFF;
    logic [31:0] fq = ev_second(op, x, y) & 64'hFFFF_FFFF;
    longint sp = longint'($signed(fp));
    longint sq = longint'($signed(fq));
    longint st = longint'(ev_extra(op, c));
    longint r;
    if (ev_is_sub(op)) r = sp - sq - st;
    else               r = sp + sq + st;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y,
                       input bit s, input logic [3:0] d, input logic [31:0] cs, input logic [31:0] ss);
    @(negedge clk);
    opc = op; a = x; b = y; sf = s; dst = d; cur_s = cs; sav_s = ss;
    #2;
  endtask

  // Full check of one vector against the requirements
  task automatic check_vec;
    bit c = cur_s[29];
    logic [2:0] eop = (opc >= 3'd6) ? 3'd0 : opc;
    logic [31:0] er = ev_result(eop, a, b, c);
    logic [3:0] ef;
    bit er_q;
    if (!sf) begin ef = cur_s[31:28]; er_q = 0; end
    else if (dst == 4'd15) begin ef = sav_s[31:28]; er_q = 1; end
    else begin
      ef = {er[31], er == 32'd0, ev_carry(eop, a, b, c), ev_ovf(eop, a, b, c)};
      er_q = 0;
    end
    if (opc >= 3'd6)                  chk("R9", "result", res, er);
    else if (opc <= 3'd1)             chk("R1", "result", res, er);
    else if (opc <= 3'd3)             chk("R2", "result", res, er);
    else                              chk("R3", "result", res, er);
    chk("R10", "restore", rst_q, er_q);
    if (!sf)                  chk("R8", "flags", flg, ef);
    else if (dst == 4'd15)    chk("R7", "flags", flg, ef);
    else begin
      chk("R4", "nz", flg[3:2], ef[3:2]);
      chk("R5", "c", flg[1], ef[1]);
      chk("R6", "v", flg[0], ef[0]);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] corner [0:5];
    void'($urandom(32'd20240613));
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'h7FFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h8000_0001;
    a = '0; b = '0; opc = '0; sf = 0; dst = '0; cur_s = '0; sav_s = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiet state: all-zero inputs
    apply(3'd0, 0, 0, 0, 0, 0, 0);
    chk("R1", "idle result", res, 0);
    chk("R8", "idle flags", flg, 0);
    chk("R10", "idle restore", rst_q, 0);

    // Directed corners
    apply(3'd0, 32'hFFFF_FFFF, 32'h1, 1, 0, 0, 0);           // R5 carry out, R4 Z
    chk("R5", "add carry", flg, 4'b0110);
    apply(3'd0, 32'h7FFF_FFFF, 32'h1, 1, 0, 0, 0);           // R6 overflow
    chk("R6", "add ovf", flg, 4'b1001);
    apply(3'd2, 32'h5, 32'h5, 1, 2, 0, 0);                   // equal: Z, C=1 no borrow
    chk("R5", "sub equal", flg, 4'b0110);
    apply(3'd2, 32'h3, 32'h5, 1, 2, 0, 0);                   // borrow
    chk("R2", "sub borrow res", res, 32'hFFFF_FFFE);
    chk("R5", "sub borrow c", flg[1], 0);
    apply(3'd3, 32'h3, 32'h5, 1, 2, 0, 0);                   // reverse
    chk("R2", "rsb res", res, 32'h2);
    apply(3'd4, 32'h5, 32'h5, 1, 2, 32'h0, 0);               // sbc with C=0
    chk("R3", "sbc c0 res", res, 32'hFFFF_FFFF);
    chk("R5", "sbc c0 carry", flg[1], 0);
    apply(3'd5, 32'h5, 32'h5, 1, 2, 32'h2000_0000, 0);       // rsc with C=1
    chk("R3", "rsc c1 res", res, 32'h0);
    apply(3'd1, 32'hFFFF_FFFF, 32'h0, 1, 1, 32'h2000_0000, 0);
    chk("R1", "adc wrap", res, 32'h0);
    chk("R5", "adc carry", flg[1], 1);
    apply(3'd2, 32'h8000_0000, 32'h1, 1, 3, 0, 0);           // signed overflow on sub
    chk("R6", "sub ovf", flg[0], 1);
    apply(3'd2, 32'h3, 32'h5, 1, 15, 32'h0, 32'hA000_0000);  // restore
    chk("R7", "restore strobe", rst_q, 1);
    chk("R7", "restore flags", flg, 4'hA);
    chk("R10", "restore result", res, 32'hFFFF_FFFE);
    apply(3'd2, 32'h3, 32'h5, 0, 15, 32'h5000_0000, 32'hA000_0000);
    chk("R8", "no S pass", flg, 4'h5);
    chk("R10", "no S no restore", rst_q, 0);
    apply(3'd7, 32'h7FFF_FFFF, 32'h1, 1, 0, 32'h2000_0000, 0);
    chk("R9", "res7 as add", res, 32'h8000_0000);
    chk("R9", "res7 flags", flg, 4'b1001);

    // Corner cross product
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int cc = 0; cc < 2; cc++) begin
            apply(3'(op), corner[i], corner[j], 1, 4'd4, {2'b00, cc[0], 29'd0}, 32'h0);
            check_vec();
          end

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      apply(3'($urandom), $urandom, $urandom, 1'($urandom),
            (($urandom % 4) == 0) ? 4'd15 : 4'($urandom),
            $urandom, $urandom);
      check_vec();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule